// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host three 8-bit general-purpose parallel ports, named A, B and C. Port C is handled as two independent 4-bit halves. The host reaches the block through a small register window. A 2-bit address, a chip select and separate read and write strobes select a port data location or the control location.

Each write to the control location carries one of two command formats, and the top bit of the word picks the format. The configuration format sets the direction of port A, port B and each half of port C. It also stores mode fields for the two port groups, and these fields do not change the behaviour of the block. The pin command format drives a single port C latch bit high or low and leaves every other setting alone. Only plain unhandshaked input and output is provided.

Every output (latches, enables and read data) comes straight from a flop. A port set as an output drives its latch onto its pins. A read of an input port returns the pin levels sampled at the read edge.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset every port is an input (all output enables 0), all output latches are 0, and the read data bus is 0.
- R2: A control write (address 3) with bit 7 = 1 sets the port directions, where 1 means input and 0 means output. Bit 4 controls port A, bit 1 controls port B, bit 3 controls the upper half of port C (pins 7..4) and bit 0 controls the lower half (pins 3..0). The new enables appear the cycle after the write.
- R3: A control write with bit 7 = 1 clears all output latches of A, B and C to 0.
- R4: The group mode fields of a configuration word (bits 6..5 and bit 2) have no effect on direction, latches or read data.
- R5: A control write with bit 7 = 0 is a pin command. Bits 3..1 select port C latch bit 0..7 and bit 0 is the value written to it. The other port C latch bits keep their values and bits 6..4 are ignored. The selected latch bit is updated even when its half is an input.
- R6: A pin command leaves all output enables and the port A and port B latches unchanged.
- R7: A write with chip select high to address 0, 1 or 2 loads port A, B or C latch respectively. A strobe while chip select is low has no effect.
- R8: A read with chip select high returns data on the read bus the cycle after the strobe. Each half returns its pins if it is an input and its latch if it is an output. Reading address 3 returns 0, and the read bus is 0 in any cycle that follows no read.
- R9: The two halves of port C work independently, so one half can be an input while the other is an output, and a single read then returns pins for one half and the latch for the other.
- R10: Control word 82h makes port A an output, port B an input and port C an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for host access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Location: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench builds the block with its default port width of 8. That is the only width the fixed control-word layout can address, since three select bits cover eight port C pins. With that width every pin command index, including the top and bottom pins of both port C halves, can be reached directly. The directed tasks also reach each direction bit on its own, mixed-direction reads of port C, and pin commands into a half that is set as an input.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } ppio_sel_e;

  // Control word field positions (decoded by the configuration register)
  localparam int CW_FMT     = 7;
  localparam int CW_A_IN    = 4;
  localparam int CW_CU_IN   = 3;
  localparam int CW_B_IN    = 1;
  localparam int CW_CL_IN   = 0;
  localparam int CW_BMODE   = 2;
  localparam int CW_AMODE_L = 5;

  typedef struct packed {
    logic [1:0] grp_a_mode;
    logic       grp_b_mode;
    logic       a_in;
    logic       b_in;
    logic       cu_in;
    logic       cl_in;
  } ppio_cfg_t;

endpackage

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
  import ppio_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output ppio_cfg_t         cfg,
  output logic              clr_latch,
  output logic              pin_en,
  output logic [IDX_W-1:0]  pin_idx,
  output logic              pin_val
);

  logic is_cfg;

  assign is_cfg    = wdata[CW_FMT];
  assign clr_latch = wr_ctrl && is_cfg;
  assign pin_en    = wr_ctrl && !is_cfg;
  assign pin_idx   = wdata[IDX_W:1];
  assign pin_val   = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.grp_a_mode <= '0;
      cfg.grp_b_mode <= 1'b0;
      cfg.a_in       <= 1'b1;
      cfg.b_in       <= 1'b1;
      cfg.cu_in      <= 1'b1;
      cfg.cl_in      <= 1'b1;
    end else if (clr_latch) begin
      cfg.grp_a_mode <= wdata[CW_AMODE_L +: 2];
      cfg.grp_b_mode <= wdata[CW_BMODE];
      cfg.a_in       <= wdata[CW_A_IN];
      cfg.b_in       <= wdata[CW_B_IN];
      cfg.cu_in      <= wdata[CW_CU_IN];
      cfg.cl_in      <= wdata[CW_CL_IN];
    end
  end

endmodule

// File: rtl/ppio_lane.sv
module ppio_lane #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] bit_we,
  input  logic         bit_val,
  input  logic         is_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_val
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (ld) begin
      q <= ld_data;
    end else begin
      for (int k = 0; k < W; k++) begin
        if (bit_we[k]) q[k] <= bit_val;
      end
    end
  end

  assign oe     = {W{~is_in}};
  assign rd_val = is_in ? pin_in : q;

endmodule

// File: rtl/ppio_rd_port.sv
module ppio_rd_port
  import ppio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [DATA_W-1:0] c_val,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mux;

  always_comb begin
    unique case (ppio_sel_e'(sel))
      SEL_A:   mux = a_val;
      SEL_B:   mux = b_val;
      SEL_C:   mux = c_val;
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata <= '0;
    else               rdata <= mux;
  end

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe
);

  localparam int HALF_W = DATA_W / 2;
  localparam int NPORT  = 3;
  localparam int NLANE  = NPORT * 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic wr_hit, rd_hit, wr_ctrl;
  assign wr_hit  = cs && wr;
  assign rd_hit  = cs && rd;
  assign wr_ctrl = wr_hit && (addr == SEL_CTRL);

  ppio_cfg_t        cfg;
  logic             clr_latch, pin_en, pin_val;
  logic [IDX_W-1:0] pin_idx;

  ppio_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wdata    (wdata),
    .cfg      (cfg),
    .clr_latch(clr_latch),
    .pin_en   (pin_en),
    .pin_idx  (pin_idx),
    .pin_val  (pin_val)
  );

  logic [DATA_W-1:0] pin_hot;
  assign pin_hot = pin_en ? (DATA_W'(1) << pin_idx) : '0;

  logic [NLANE-1:0]             ln_in;
  logic [NLANE-1:0][HALF_W-1:0] ln_q, ln_oe, ln_rd, ln_pin;

  assign ln_in  = {cfg.cu_in, cfg.cl_in, cfg.b_in, cfg.b_in, cfg.a_in, cfg.a_in};
  assign ln_pin = {pc_in, pb_in, pa_in};

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [HALF_W-1:0] we;
    if (i / 2 == int'(SEL_C)) begin : g_c
      assign we = pin_hot[(i % 2) * HALF_W +: HALF_W];
    end else begin : g_ab
      assign we = '0;
    end

    ppio_lane #(.W(HALF_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_latch),
      .ld     (wr_hit && (addr == 2'(i / 2))),
      .ld_data(wdata[(i % 2) * HALF_W +: HALF_W]),
      .bit_we (we),
      .bit_val(pin_val),
      .is_in  (ln_in[i]),
      .pin_in (ln_pin[i]),
      .q      (ln_q[i]),
      .oe     (ln_oe[i]),
      .rd_val (ln_rd[i])
    );
  end

  assign {pc_out, pb_out, pa_out} = ln_q;
  assign {pc_oe,  pb_oe,  pa_oe}  = ln_oe;

  ppio_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .rd_en(rd_hit),
    .sel  (addr),
    .a_val({ln_rd[1], ln_rd[0]}),
    .b_val({ln_rd[3], ln_rd[2]}),
    .c_val({ln_rd[5], ln_rd[4]}),
    .rdata(rdata)
  );

endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] pa_out,
  input logic [DATA_W-1:0] pa_oe,
  input logic [DATA_W-1:0] pb_out,
  input logic [DATA_W-1:0] pb_oe,
  input logic [DATA_W-1:0] pc_out,
  input logic [DATA_W-1:0] pc_oe
);

  logic cfg_wr, pin_wr, any_wr, rd_ctrl, any_rd;
  assign cfg_wr  = cs && wr && addr == 2'd3 && wdata[7];
  assign pin_wr  = cs && wr && addr == 2'd3 && !wdata[7];
  assign any_wr  = cs && wr;
  assign rd_ctrl = cs && rd && addr == 2'd3;
  assign any_rd  = cs && rd;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                    pa_out == '0 && pb_out == '0 && pc_out == '0 && rdata == '0));

  p_cfg_dir_a_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_wr)) |-> pa_oe == {DATA_W{~$past(wdata[4])}});

  p_cfg_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_wr)) |-> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  p_pin_keep_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_wr)) |->
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out) && $stable(pb_out)));

  p_pin_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_wr)) |-> $countones(pc_out ^ $past(pc_out)) <= 1);

  p_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_wr)) |->
      ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
       $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_ctrl_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_ctrl) || !$past(any_rd))) |-> rdata == '0);

endmodule

bind ppio_ctrl ppio_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs    (cs),
  .rd    (rd),
  .wr    (wr),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .pa_out(pa_out),
  .pa_oe (pa_oe),
  .pb_out(pb_out),
  .pb_oe (pb_oe),
  .pc_out(pc_out),
  .pc_oe (pc_oe)
);

// File: tb/test_ppio_ctrl.sv
`timescale 1ns/100ps
module test_ppio_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ppio_ctrl i_ppio_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 outs", pa_out | pb_out | pc_out, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    pa_in = 8'hC9;
    bus_rd(2'd0, v);
    chk("R8 input A reads pins", v, 8'hC9);
  endtask

  task automatic t_ctrl82();
    logic [7:0] v;
    bus_wr(2'd3, 8'h82);
    chk("R10 A out", pa_oe, 8'hFF);
    chk("R10 B in", pb_oe, 8'h00);
    chk("R10 C out", pc_oe, 8'hFF);
    pb_in = 8'h5A;
    bus_rd(2'd1, v);
    chk("R8 input B reads pins", v, 8'h5A);
  endtask

  task automatic t_dir_bits();
    int pos [4] = '{0, 1, 3, 4};
    for (int j = 0; j < 4; j++) begin
      logic [7:0] ea, eb, ec;
      bus_wr(2'd3, 8'h80 | (8'h01 << pos[j]));
      ea = (pos[j] == 4) ? 8'h00 : 8'hFF;
      eb = (pos[j] == 1) ? 8'h00 : 8'hFF;
      ec = (pos[j] == 0) ? 8'hF0 : (pos[j] == 3) ? 8'h0F : 8'hFF;
      chk("R2 pa_oe", pa_oe, ea);
      chk("R2 pb_oe", pb_oe, eb);
      chk("R2 pc_oe", pc_oe, ec);
    end
  endtask

  task automatic t_clear();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h3C);
    bus_wr(2'd1, 8'h99);
    bus_wr(2'd2, 8'hC3);
    chk("R7 A load", pa_out, 8'h3C);
    chk("R7 B load", pb_out, 8'h99);
    chk("R7 C load", pc_out, 8'hC3);
    bus_wr(2'd3, 8'h80);
    chk("R3 A cleared", pa_out, 8'h00);
    chk("R3 B cleared", pb_out, 8'h00);
    chk("R3 C cleared", pc_out, 8'h00);
  endtask

  task automatic t_pin_cmd();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'b0111_1011);
    chk("R5 set pin 5, upper bits ignored", pc_out, 8'h20);
    bus_wr(2'd3, 8'b0000_0001);
    chk("R5 set pin 0", pc_out, 8'h21);
    bus_wr(2'd3, 8'b0000_1111);
    chk("R5 set pin 7", pc_out, 8'hA1);
    bus_wr(2'd3, 8'b0101_1010);
    chk("R5 clear pin 5", pc_out, 8'h81);
  endtask

  task automatic t_pin_keep();
    bus_wr(2'd3, 8'h8A);
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd1, 8'h12);
    bus_wr(2'd3, 8'h0D);
    chk("R6 pa_oe kept", pa_oe, 8'hFF);
    chk("R6 pb_oe kept", pb_oe, 8'h00);
    chk("R6 pc_oe kept", pc_oe, 8'h0F);
    chk("R6 A latch kept", pa_out, 8'h77);
    chk("R6 B latch kept", pb_out, 8'h12);
    chk("R5 pin 6 into input half", pc_out, 8'h40);
  endtask

  task automatic t_mode_inert();
    logic [7:0] v;
    bus_wr(2'd3, 8'hE4);
    chk("R4 pa_oe", pa_oe, 8'hFF);
    chk("R4 pb_oe", pb_oe, 8'hFF);
    chk("R4 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'hAA);
    bus_rd(2'd0, v);
    chk("R4 A data path", v, 8'hAA);
    chk("R4 A latch", pa_out, 8'hAA);
  endtask

  task automatic t_split_read();
    logic [7:0] v;
    bus_wr(2'd3, 8'h81);
    chk("R9 pc_oe split", pc_oe, 8'hF0);
    bus_wr(2'd2, 8'hB7);
    pc_in = 8'h5E;
    bus_rd(2'd2, v);
    chk("R9 mixed C read", v, 8'hBE);
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'h3C);
    bus_rd(2'd2, v);
    chk("R9 opposite split", v, 8'h5C);
    bus_rd(2'd3, v);
    chk("R8 control reads zero", v, 8'h00);
    @(negedge clk);
    chk("R8 idle read bus zero", rdata, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5D);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk);
    wr = 1'b0;
    chk("R7 no cs no write", pa_out, 8'h5D);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = 2'd3; wdata = 8'h9B;
    @(negedge clk);
    wr = 1'b0;
    chk("R7 no cs no config", pa_oe, 8'hFF);
    @(negedge clk);
    cs = 1'b0; rd = 1'b1; addr = 2'd0;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
    chk("R8 no cs no read", v, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl82();
    t_dir_bits();
    t_clear();
    t_pin_cmd();
    t_pin_keep();
    t_mode_inert();
    t_split_read();
    t_ignored();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule